// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps through a microprogram held in its own 32-bit-wide microstore and drives the register transfers of a small accumulator machine. Every microinstruction takes two clocks. In the fetch clock the word addressed by the micro program counter is latched into the microinstruction register and the counter advances by one. In the execute clock the latched word is decoded into one of four classes and acted on. The classes are a register transfer over two source buses and a small ALU, a conditional or unconditional branch within the microprogram, an I/O request, and a microstore transfer. The microstore transfer is accepted and does nothing.

The machine state is the program counter, instruction register, memory address register, memory data register and accumulator. A second memory-mapped word comes in on an input port. The microstore is filled through a write port, normally while reset is held. The first microprogram usually does an instruction fetch: MAR from PC, PC incremented, a memory read, then IR from MDR, and then the exit code. The exit code stops the sequencer and raises halt. Only reset starts it again.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer clears the micro program counter, the microinstruction register, halt, PC, IR, MAR, MDR, the accumulator and the held ALU output to zero. It starts in the fetch clock. The microstore keeps its contents.
- R2: A fetch clock loads the word at the micro program counter and adds one to the counter, wrapping at 12 bits. The next clock is an execute clock, and in that clock the counter changes only through a taken branch. Bits 31:30 of the word select the class: 00 register transfer, 01 branch, 10 I/O, 11 microstore transfer (no effect).
- R3: In a register transfer, bits 29:27 select the A bus: 0 is zero, 1 is the accumulator, 2 is PC, 3 is IR, and codes 4 to 7 are zero.
- R4: Bits 26:24 select the B bus: 0 is MDR, 1 is MAR, 2 is the `mem1_in` word, 3 is the constant 1, and codes 4 to 7 are zero.
- R5: Bits 23:20 select the function: 0 gives A, 1 gives A+B modulo 2^16, and 2 gives B. Codes 3 to 15 keep the ALU output of the last transfer.
- R6: Bits 19:16 are destination enables: bit 19 is the accumulator, bit 18 is MAR, bit 17 is PC and bit 16 is IR. Any combination may be set. They are written at the end of the execute clock, and no other class changes them.
- R7: In a branch, bits 11:0 are the target and bit 12 is the polarity. A 1 means jump when the condition is true, a 0 means jump when it is false. A jump loads the target into the micro program counter. Otherwise execution continues with the next word.
- R8: Bits 15:13 choose the condition: 0 means the accumulator is positive (sign bit clear and non-zero), 1 negative (sign bit set), 2 zero, and 6 always. Codes 3, 4 and 5 never jump, whatever the polarity.
- R9: Condition code 7 is the exit. From the next edge `halt` is high, and the micro program counter and all machine registers hold until reset.
- R10: An I/O word with bits 29:27 equal to 0 raises `mem_rd` during its execute clock, and MDR takes `mem_rdata` at the end of that clock. Other I/O codes have no effect.
- R11: Microstore writes through `ld_en`/`ld_addr`/`ld_data` take effect at the clock edge. A fetch reads entry (micro program counter modulo the depth), so branch targets above the depth wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Microstore write enable |
| ld_addr | input | 6 | Microstore write index |
| ld_data | input | 32 | Microstore write word |
| mem_rdata | input | 16 | Data returned by machine memory |
| mem1_in | input | 16 | Memory-mapped word on B-bus source 2 |
| mem_rd | output | 1 | Machine memory read strobe |
| mem_addr | output | 16 | MAR contents |
| pc_out | output | 16 | Program counter |
| ir_out | output | 16 | Instruction register |
| acc_out | output | 16 | Accumulator |
| upc_out | output | 12 | Micro program counter |
| halt | output | 1 | Sequencer stopped by exit code |

## Verification
The hardest cases to reach are the branch conditions under both polarities for each accumulator state. The accumulator can only be set by running microcode, so the bench runs one branch ladder three times, with `mem1_in` holding a negative, a zero and a positive word. A transfer at the start of the ladder copies that word into the accumulator, so every condition is tested both taken and not taken. The ladder ends with a jump to a target above the microstore depth, which tests the wrap of the fetch index. After each exit the bench keeps writing the microstore and toggling `mem_rdata`, to show that the halted state stays frozen.

// File: rtl/useq_pkg.sv
// Shared types for the microsequencer: instruction classes and the
// decoded view of a 32-bit microword. Assumes the fixed field layout.
package useq_pkg;

    localparam int UWORD_W = 32;
    localparam int UADDR_W = 12;

    typedef enum logic [1:0] {
        CLS_XFER = 2'b00,
        CLS_BR   = 2'b01,
        CLS_IO   = 2'b10,
        CLS_USTO = 2'b11
    } cls_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    localparam logic [2:0] COND_POS  = 3'd0;
    localparam logic [2:0] COND_NEG  = 3'd1;
    localparam logic [2:0] COND_ZERO = 3'd2;
    localparam logic [2:0] COND_ALW  = 3'd6;
    localparam logic [2:0] COND_EXIT = 3'd7;

    typedef struct packed {
        cls_e               cls;
        logic [2:0]         asel;
        logic [2:0]         bsel;
        logic [3:0]         fn;
        logic [3:0]         dst;
        logic [2:0]         cond;
        logic               pol;
        logic [UADDR_W-1:0] tgt;
        logic [2:0]         iosel;
    } uop_t;

endpackage

// File: rtl/useq_decode.sv
// Field decoder: splits a microword into its named fields.
// Purely combinational; assumes the fixed 32-bit layout.
module useq_decode
    import useq_pkg::*;
(
    input  logic [UWORD_W-1:0] mir,
    output uop_t               uop
);

    // Slice each field out of the word.
    always_comb begin
        uop.cls   = cls_e'(mir[31:30]);
        uop.asel  = mir[29:27];
        uop.bsel  = mir[26:24];
        uop.fn    = mir[23:20];
        uop.dst   = mir[19:16];
        uop.cond  = mir[15:13];
        uop.pol   = mir[12];
        uop.tgt   = mir[11:0];
        uop.iosel = mir[29:27];
    end

endmodule

// File: rtl/useq_cond.sv
// Branch evaluator: tests the accumulator against the selected condition
// and applies the polarity bit. Codes without a condition never jump.
module useq_cond #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [2:0]        cond,
    input  logic              pol,
    output logic              take,
    output logic              is_exit
);
    import useq_pkg::*;

    logic sgn, zro, hit, valid;

    // Flags of the accumulator.
    always_comb begin
        sgn = acc[DATA_W-1];
        zro = (acc == '0);
    end

    // Condition select and polarity.
    always_comb begin
        hit   = 1'b0;
        valid = 1'b1;
        case (cond)
            COND_POS:  hit = !sgn && !zro;
            COND_NEG:  hit = sgn;
            COND_ZERO: hit = zro;
            COND_ALW:  hit = 1'b1;
            default:   valid = 1'b0;
        endcase
        take    = valid && (hit == pol);
        is_exit = (cond == COND_EXIT);
    end

endmodule

// File: rtl/useq_datapath.sv
// Machine datapath: two source buses, a small ALU with a held output,
// and the PC/IR/MAR/MDR/accumulator registers. Writes only when enabled.
module useq_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_xfer,
    input  logic [2:0]        asel,
    input  logic [2:0]        bsel,
    input  logic [3:0]        fn,
    input  logic [3:0]        dst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] mem1_in,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] mar,
    output logic [DATA_W-1:0] acc
);

    logic [DATA_W-1:0] mdr, obus_q, abus, bbus, obus_nxt;

    // A-bus source select.
    always_comb begin
        case (asel)
            3'd1:    abus = acc;
            3'd2:    abus = pc;
            3'd3:    abus = ir;
            default: abus = '0;
        endcase
    end

    // B-bus source select.
    always_comb begin
        case (bsel)
            3'd0:    bbus = mdr;
            3'd1:    bbus = mar;
            3'd2:    bbus = mem1_in;
            3'd3:    bbus = DATA_W'(1);
            default: bbus = '0;
        endcase
    end

    // ALU function; unused codes keep the previous result.
    always_comb begin
        case (fn)
            4'd0:    obus_nxt = abus;
            4'd1:    obus_nxt = abus + bbus;
            4'd2:    obus_nxt = bbus;
            default: obus_nxt = obus_q;
        endcase
    end

    // Register writes at the end of the execute clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; ir <= '0; mar <= '0; acc <= '0; mdr <= '0; obus_q <= '0;
        end else begin
            if (en_xfer) begin
                obus_q <= obus_nxt;
                if (dst[3]) acc <= obus_nxt;
                if (dst[2]) mar <= obus_nxt;
                if (dst[1]) pc  <= obus_nxt;
                if (dst[0]) ir  <= obus_nxt;
            end
            if (rd_en) mdr <= mem_rdata;
        end
    end

    assert_idle_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_xfer |=> ($stable(pc) && $stable(ir) && $stable(mar) && $stable(acc)));

    assert_mdr_only_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(mdr));

    assert_held_function_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_xfer && fn > 4'd2 && dst[3]) |=> (acc == $past(obus_q)));

endmodule

// File: rtl/useq_ctrl.sv
// Top of the microsequencer: microstore, micro program counter, MIR,
// two-clock fetch/execute stepping and halt. Assumes STORE_DEPTH is a
// power of two no larger than 4096.
module useq_ctrl #(
    parameter int DATA_W      = 16,
    parameter int STORE_DEPTH = 64,
    localparam int IDX_W      = $clog2(STORE_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en,
    input  logic [IDX_W-1:0]              ld_addr,
    input  logic [useq_pkg::UWORD_W-1:0]  ld_data,
    input  logic [DATA_W-1:0]             mem_rdata,
    input  logic [DATA_W-1:0]             mem1_in,
    output logic                          mem_rd,
    output logic [DATA_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             pc_out,
    output logic [DATA_W-1:0]             ir_out,
    output logic [DATA_W-1:0]             acc_out,
    output logic [useq_pkg::UADDR_W-1:0]  upc_out,
    output logic                          halt
);
    import useq_pkg::*;

    logic [UWORD_W-1:0] ustore [STORE_DEPTH];
    logic [UWORD_W-1:0] mir;
    logic [UADDR_W-1:0] upc;
    phase_e             phase;
    uop_t               uop;
    logic               exec, en_xfer, rd_en, is_br, take, is_exit;

    // Microstore write port.
    always_ff @(posedge clk) begin
        if (ld_en) ustore[ld_addr] <= ld_data;
    end

    useq_decode u_decode (
        .mir (mir),
        .uop (uop)
    );

    useq_cond #(.DATA_W(DATA_W)) u_cond (
        .acc     (acc_out),
        .cond    (uop.cond),
        .pol     (uop.pol),
        .take    (take),
        .is_exit (is_exit)
    );

    // Execute-clock qualifiers per class.
    always_comb begin
        exec    = (phase == PH_EXEC) && !halt;
        en_xfer = exec && (uop.cls == CLS_XFER);
        rd_en   = exec && (uop.cls == CLS_IO) && (uop.iosel == 3'd0);
        is_br   = exec && (uop.cls == CLS_BR);
    end

    useq_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_xfer   (en_xfer),
        .asel      (uop.asel),
        .bsel      (uop.bsel),
        .fn        (uop.fn),
        .dst       (uop.dst),
        .rd_en     (rd_en),
        .mem_rdata (mem_rdata),
        .mem1_in   (mem1_in),
        .pc        (pc_out),
        .ir        (ir_out),
        .mar       (mem_addr),
        .acc       (acc_out)
    );

    // Fetch/execute stepping, branching and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc   <= '0;
            mir   <= '0;
            phase <= PH_FETCH;
            halt  <= 1'b0;
        end else if (!halt) begin
            if (phase == PH_FETCH) begin
                mir   <= ustore[upc[IDX_W-1:0]];
                upc   <= upc + UADDR_W'(1);
                phase <= PH_EXEC;
            end else begin
                phase <= PH_FETCH;
                if (is_br) begin
                    if (is_exit)   halt <= 1'b1;
                    else if (take) upc  <= uop.tgt;
                end
            end
        end
    end

    always_comb begin
        mem_rd  = rd_en;
        upc_out = upc;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (upc == '0 && !halt && phase == PH_FETCH));

    assert_fetch_then_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && !halt) |=> (phase == PH_EXEC && upc == $past(upc) + UADDR_W'(1)));

    assert_taken_loads_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && take && !is_exit) |=> (upc == $past(uop.tgt)));

    assert_exec_keeps_upc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !(is_br && take)) |=> (upc == $past(upc)));

    assert_halt_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && $stable(upc) && $stable(pc_out) && $stable(acc_out)));

    assert_read_in_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (phase == PH_EXEC && !halt));

endmodule

// File: tb/useq_ctrl_tb.sv
// Bench for useq_ctrl: a behavioural model is stepped at every rising
// edge and every visible output is compared at the falling edge.
module useq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem1_in = '0;
    logic          mem_rd;
    logic [DW-1:0] mem_addr, pc_out, ir_out, acc_out;
    logic [11:0]   upc_out;
    logic          halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .mem_rdata(mem_rdata), .mem1_in(mem1_in),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .pc_out(pc_out),
        .ir_out(ir_out), .acc_out(acc_out), .upc_out(upc_out), .halt(halt)
    );

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // Model state.
    logic [31:0]   m_store [64];
    logic [31:0]   m_mir;
    logic [11:0]   m_upc;
    logic          m_phase, m_halt;
    logic [DW-1:0] m_pc, m_ir, m_mar, m_mdr, m_acc, m_obus;
    logic [31:0]   prog [16];

    function automatic logic [31:0] xf(int a, int b, int f, int d);
        return {2'b00, 3'(a), 3'(b), 4'(f), 4'(d), 16'h0};
    endfunction
    function automatic logic [31:0] br(int c, int p, int t);
        return {2'b01, 14'h0, 3'(c), 1'(p), 12'(t)};
    endfunction
    function automatic logic [31:0] io(int c);
        return {2'b10, 3'(c), 27'h0};
    endfunction

    task automatic model_step();
        logic [DW-1:0] a, b, o;
        logic cnd, valid;
        if (!rst_n) begin
            m_upc = '0; m_mir = '0; m_phase = 1'b0; m_halt = 1'b0;
            m_pc = '0; m_ir = '0; m_mar = '0; m_mdr = '0; m_acc = '0; m_obus = '0;
        end else if (!m_halt) begin
            if (!m_phase) begin
                m_mir = m_store[m_upc % 64];
                m_upc = m_upc + 12'd1;
                m_phase = 1'b1;
            end else begin
                m_phase = 1'b0;
                if (m_mir[31:30] == 2'b00) begin
                    case (int'(m_mir[29:27]))
                        1: a = m_acc; 2: a = m_pc; 3: a = m_ir; default: a = 0;
                    endcase
                    case (int'(m_mir[26:24]))
                        0: b = m_mdr; 1: b = m_mar; 2: b = mem1_in; 3: b = 1; default: b = 0;
                    endcase
                    case (int'(m_mir[23:20]))
                        0: o = a; 1: o = a + b; 2: o = b; default: o = m_obus;
                    endcase
                    m_obus = o;
                    if (m_mir[19]) m_acc = o;
                    if (m_mir[18]) m_mar = o;
                    if (m_mir[17]) m_pc = o;
                    if (m_mir[16]) m_ir = o;
                end else if (m_mir[31:30] == 2'b01) begin
                    valid = 1'b1; cnd = 1'b0;
                    case (int'(m_mir[15:13]))
                        0: cnd = !m_acc[DW-1] && (m_acc != 0);
                        1: cnd = m_acc[DW-1];
                        2: cnd = (m_acc == 0);
                        6: cnd = 1'b1;
                        default: valid = 1'b0;
                    endcase
                    if (m_mir[15:13] == 3'd7) m_halt = 1'b1;
                    else if (valid && cnd == m_mir[12]) m_upc = m_mir[11:0];
                end else if (m_mir[31:30] == 2'b10) begin
                    if (m_mir[29:27] == 3'd0) m_mdr = mem_rdata;
                end
            end
        end
        if (ld_en) m_store[ld_addr] = ld_data;
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic exp_rd;
        exp_rd = m_phase && !m_halt && m_mir[31:30] == 2'b10 && m_mir[29:27] == 3'd0;
        chk("upc", 32'(upc_out), 32'(m_upc));
        chk("pc", 32'(pc_out), 32'(m_pc));
        chk("ir", 32'(ir_out), 32'(m_ir));
        chk("mar", 32'(mem_addr), 32'(m_mar));
        chk("acc", 32'(acc_out), 32'(m_acc));
        chk("halt", 32'(halt), 32'(m_halt));
        chk("mem_rd", 32'(mem_rd), 32'(exp_rd));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    // Load n words under reset (R1, R11), run up to maxc clocks, then
    // keep clocking with stray activity to show the halted freeze (R9).
    task automatic run_prog(int n, int maxc);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            ld_en = 1'b1; ld_addr = 6'(i); ld_data = prog[i];
            cyc();
        end
        ld_en = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < maxc && !m_halt; i++) cyc();
        for (int i = 0; i < 6; i++) begin
            ld_en = 1'b1; ld_addr = 6'(40 + i); ld_data = 32'hDEAD_0000 + 32'(i);
            mem_rdata = ~mem_rdata;
            cyc();
        end
        ld_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_store[i] = 'x;
        m_upc = '0; m_mir = '0; m_phase = 1'b0; m_halt = 1'b0;
        m_pc = '0; m_ir = '0; m_mar = '0; m_mdr = '0; m_acc = '0; m_obus = '0;
        @(negedge clk);

        // R1 R2 R10: instruction fetch routine with a preset PC.
        cur_req = "R1,R2,R10";
        mem1_in = 16'h1234; mem_rdata = 16'hBEEF;
        prog[0] = xf(0, 2, 2, 4'b1000);
        prog[1] = xf(1, 3, 1, 4'b0010);
        prog[2] = xf(2, 0, 0, 4'b0100);
        prog[3] = xf(2, 3, 1, 4'b0010);
        prog[4] = io(0);
        prog[5] = xf(0, 0, 2, 4'b0001);
        prog[6] = br(7, 0, 0);
        run_prog(7, 60);

        // R1: reset mid-program, part-way through the same routine.
        cur_req = "R1";
        run_prog(7, 5);

        // R3 R4 R5 R6 R10: every source, held function, multiple destinations, no-op classes.
        cur_req = "R3,R4,R5,R6,R10";
        mem1_in = 16'h0F0F; mem_rdata = 16'h7001;
        prog[0]  = xf(0, 2, 2, 4'b1000);
        prog[1]  = xf(1, 2, 1, 4'b0100);
        prog[2]  = xf(0, 1, 2, 4'b0011);
        prog[3]  = xf(3, 3, 1, 4'b1000);
        prog[4]  = xf(2, 1, 9, 4'b1001);
        prog[5]  = xf(5, 3, 1, 4'b0010);
        prog[6]  = io(3);
        prog[7]  = 32'hC000_1234;
        prog[8]  = io(0);
        prog[9]  = xf(2, 0, 1, 4'b0001);
        prog[10] = xf(3, 6, 1, 4'b0100);
        prog[11] = br(7, 1, 0);
        run_prog(12, 80);

        // R7 R8 R9 R11: branch ladder run with a negative, zero and positive accumulator.
        cur_req = "R7,R8,R9,R11";
        prog[0]  = xf(0, 2, 2, 4'b1000);
        prog[1]  = br(1, 1, 3);
        prog[2]  = xf(2, 3, 1, 4'b0010);
        prog[3]  = br(0, 0, 5);
        prog[4]  = xf(0, 3, 1, 4'b0001);
        prog[5]  = br(2, 1, 7);
        prog[6]  = xf(0, 3, 1, 4'b0100);
        prog[7]  = br(4, 1, 0);
        prog[8]  = br(6, 0, 0);
        prog[9]  = br(6, 1, 12'h04B);
        prog[10] = xf(1, 3, 1, 4'b1000);
        prog[11] = br(7, 0, 0);
        mem1_in = 16'h8000; run_prog(12, 80);
        mem1_in = 16'h0000; run_prog(12, 80);
        mem1_in = 16'h0005; run_prog(12, 80);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule